// File: doc/BRIEF.md
# Programmable Divided Reference Clock

This block produces a free-running clock for an off-chip device. It picks one of three reference clocks and divides it by a programmable ratio. Software controls it through one 32-bit control word on a simple write port in the system-clock domain. A read port returns the current control word. The word holds three fields: an output enable, a 2-bit reference select and an 8-bit ratio field. The output period is (ratio field + 1) periods of the selected reference. A ratio field of zero passes the reference through unchanged.

Each reference has its own divider, which runs in that reference's clock domain. The control fields reach each divider through a synchronizer, followed by a stability filter. A divider adopts new settings only when its current output period ends. This gives glitch-free changes of ratio, enable and source. The divider outputs are OR-ed onto the output pin. An idle divider always holds its output low, so the OR is safe. The output has no defined phase relationship to the system clock.

Top module: `refdiv_top`

## Requirements
- R1: A write stores bit 31 (enable), bits 17:16 (reference select) and bits 7:0 (ratio field). The read port shows the stored word from the cycle after the write, and holds it while no write occurs.
- R2: Bits 30:18 and 15:8 always read as 0, whatever value is written to them.
- R3: After reset the read port shows 0x00000000 and the output clock stays low.
- R4: While bit 31 is 0, the output stays low with no rising edges, whatever the other fields hold.
- R5: Reference select code 3 holds the output low even when enabled. Code 0 selects the system clock, code 1 the first oscillator input and code 2 the second oscillator input.
- R6: With a ratio field D of 1 or more, the output period is exactly (D+1) periods of the selected reference.
- R7: With a ratio field of 0, the output follows the selected reference: same period and same high time.
- R8: With a ratio N = D+1 of 2 or more, the output is high for floor(N/2) reference periods and low for the rest of each period.
- R9: A new ratio takes effect only at the end of the output period in progress. The current high and low phases complete at their old lengths.
- R10: Clearing the enable lets the current high phase finish at full length. The output then stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock; also reference code 0 |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| osc_a_clk | input | 1 | First oscillator reference (code 1) |
| osc_b_clk | input | 1 | Second oscillator reference (code 2) |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, reserved bits zero |
| clk_out | output | 1 | Divided reference clock for the external device |

## Verification
The hardest case to reach from the ports is a control change that lands in the middle of an output period. The period must run out at its old length before the new setting applies.

The bench waits for a rising edge of the output and writes a new ratio, or clears the enable, during that high phase. It then times the remaining high phase and the following period against both the old and the new expected lengths. Periods are measured on three references running at unrelated frequencies, including ratio fields of 0, 1 and 255 and odd ratios.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int DIV_W   = 8;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 3;
  localparam int EN_BIT  = 31;
  localparam int SEL_LSB = 16;
  localparam int DIV_LSB = 0;

  localparam logic [31:0] RW_MASK =
      (32'd1 << EN_BIT) |
      (((32'd1 << SEL_W) - 32'd1) << SEL_LSB) |
      (((32'd1 << DIV_W) - 32'd1) << DIV_LSB);

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  function automatic logic [31:0] pack_ctrl(ctrl_t c);
    logic [31:0] r;
    r                  = '0;
    r[EN_BIT]          = c.en;
    r[SEL_LSB +: SEL_W] = c.sel;
    r[DIV_LSB +: DIV_W] = c.div;
    return r;
  endfunction
endpackage

// File: rtl/refdiv_regs.sv
module refdiv_regs
  import refdiv_pkg::*;
(
  input  logic               sys_clk,
  input  logic               sys_rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic [NUM_SRC-1:0] dom_en,
  output logic [DIV_W-1:0]   dom_div
);
  ctrl_t ctrl_q;
  logic  unused_rsvd;

  // Reserved bits are never stored (R2).
  assign unused_rsvd = ^(wr_data & ~RW_MASK);

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.en  <= wr_data[EN_BIT];
      ctrl_q.sel <= wr_data[SEL_LSB +: SEL_W];
      ctrl_q.div <= wr_data[DIV_LSB +: DIV_W];
    end
  end

  assign rd_data = pack_ctrl(ctrl_q);

  // Launch flops for the crossing: one enable per reference, code 3 selects none (R5)
  always_ff @(posedge sys_clk) begin
    if (sys_rst) dom_div <= '0;
    else         dom_div <= ctrl_q.div;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
    always_ff @(posedge sys_clk) begin
      if (sys_rst) dom_en[i] <= 1'b0;
      else         dom_en[i] <= ctrl_q.en && (ctrl_q.sel == SEL_W'(i));
    end
  end
endmodule

// File: rtl/refdiv_src_div.sv
module refdiv_src_div
  import refdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             sys_rst,
  input  logic             cfg_en,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             div_out,
  output logic             dom_rst,
  output logic             cur_en,
  output logic [DIV_W-1:0] cur_div,
  output logic [DIV_W-1:0] cnt,
  output logic             q
);
  localparam int CW = DIV_W + 1;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic [CW-1:0]          cfg_pipe [SYNC_STAGES+1];
  logic                   stable, wrap, byp_q, gate_n;
  logic                   n_en, n_q, n_byp;
  logic [DIV_W-1:0]       n_div, n_cnt;
  logic [DIV_W:0]         n_hi;

  always_ff @(posedge src_clk)
    rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], sys_rst};
  assign dom_rst = rst_pipe[SYNC_STAGES-1];

  // Synchronizer followed by one compare stage that filters out skewed bus bits
  always_ff @(posedge src_clk) begin
    if (dom_rst) cfg_pipe[0] <= '0;
    else         cfg_pipe[0] <= {cfg_en, cfg_div};
  end
  for (genvar k = 1; k <= SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge src_clk) begin
      if (dom_rst) cfg_pipe[k] <= '0;
      else         cfg_pipe[k] <= cfg_pipe[k-1];
    end
  end
  assign stable = (cfg_pipe[SYNC_STAGES] == cfg_pipe[SYNC_STAGES-1]);

  // New settings are adopted only at the end of a period (R9, R10)
  assign wrap = !cur_en || (cnt == cur_div);

  always_comb begin
    n_en  = cur_en;
    n_div = cur_div;
    n_cnt = cnt + 1'b1;
    if (wrap) begin
      n_cnt = '0;
      if (stable) {n_en, n_div} = cfg_pipe[SYNC_STAGES-1];
    end
    n_hi  = ({1'b0, n_div} + 1'b1) >> 1;
    n_q   = n_en && (n_div != '0) && ({1'b0, n_cnt} < n_hi);
    n_byp = n_en && (n_div == '0);
  end

  always_ff @(posedge src_clk) begin
    if (dom_rst) begin
      cur_en  <= 1'b0;
      cur_div <= '0;
      cnt     <= '0;
      q       <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      cur_en  <= n_en;
      cur_div <= n_div;
      cnt     <= n_cnt;
      q       <= n_q;
      byp_q   <= n_byp;
    end
  end

  // Divide-by-one path: gate changes only while the reference is low (R7)
  always_ff @(negedge src_clk) begin
    if (dom_rst) gate_n <= 1'b0;
    else         gate_n <= byp_q;
  end

  assign div_out = q | (src_clk & gate_n);
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        sys_clk,
  input  logic        sys_rst,
  input  logic        osc_a_clk,
  input  logic        osc_b_clk,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        clk_out
);
  logic [NUM_SRC-1:0]            src_clks;
  logic [NUM_SRC-1:0]            dom_en, dom_out, dom_rst, dom_cur_en, dom_q;
  logic [DIV_W-1:0]              dom_div;
  logic [NUM_SRC-1:0][DIV_W-1:0] dom_cur_div, dom_cnt;

  assign src_clks = {osc_b_clk, osc_a_clk, sys_clk};

  refdiv_regs u_regs (
    .sys_clk (sys_clk),
    .sys_rst (sys_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .dom_en  (dom_en),
    .dom_div (dom_div)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dom
    refdiv_src_div #(.SYNC_STAGES(SYNC_STAGES)) u_div (
      .src_clk (src_clks[i]),
      .sys_rst (sys_rst),
      .cfg_en  (dom_en[i]),
      .cfg_div (dom_div),
      .div_out (dom_out[i]),
      .dom_rst (dom_rst[i]),
      .cur_en  (dom_cur_en[i]),
      .cur_div (dom_cur_div[i]),
      .cnt     (dom_cnt[i]),
      .q       (dom_q[i])
    );
  end

  // Idle dividers hold low, so OR-ing is safe during a source switch
  assign clk_out = |dom_out;
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
  import refdiv_pkg::*;
(
  input logic                          sys_clk,
  input logic                          sys_rst,
  input logic                          wr_en,
  input logic [31:0]                   wr_data,
  input logic [31:0]                   rd_data,
  input logic [NUM_SRC-1:0]            src_clks,
  input logic [NUM_SRC-1:0]            dom_rst,
  input logic [NUM_SRC-1:0]            dom_cur_en,
  input logic [NUM_SRC-1:0]            dom_q,
  input logic [NUM_SRC-1:0][DIV_W-1:0] dom_cur_div,
  input logic [NUM_SRC-1:0][DIV_W-1:0] dom_cnt
);
  // R1 and R2: write is visible next cycle with reserved bits cleared
  p_readback_r1: assert property (@(posedge sys_clk) disable iff (sys_rst)
    wr_en |=> (rd_data == ($past(wr_data) & RW_MASK)));

  p_hold_r1: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !wr_en |=> $stable(rd_data));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    p_idle_low_r4: assert property (@(posedge src_clks[i]) disable iff (dom_rst[i])
      !dom_cur_en[i] |-> !dom_q[i]);

    p_cnt_range_r6: assert property (@(posedge src_clks[i]) disable iff (dom_rst[i])
      dom_cnt[i] <= dom_cur_div[i]);

    p_duty_r8: assert property (@(posedge src_clks[i]) disable iff (dom_rst[i])
      (dom_cur_en[i] && dom_cur_div[i] != '0) |->
        (dom_q[i] == ({1'b0, dom_cnt[i]} < (({1'b0, dom_cur_div[i]} + 1'b1) >> 1))));

    p_mid_period_r9: assert property (@(posedge src_clks[i]) disable iff (dom_rst[i])
      (dom_cur_en[i] && dom_cnt[i] != dom_cur_div[i]) |=>
        ($stable(dom_cur_div[i]) && dom_cur_en[i]));
  end
endmodule

bind refdiv_top refdiv_checker u_chk (
  .sys_clk     (sys_clk),
  .sys_rst     (sys_rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .src_clks    (src_clks),
  .dom_rst     (dom_rst),
  .dom_cur_en  (dom_cur_en),
  .dom_q       (dom_q),
  .dom_cur_div (dom_cur_div),
  .dom_cnt     (dom_cnt)
);

// File: tb/sim_refdiv_top.sv
`timescale 1ns/1ps
module sim_refdiv_top;
  logic        sys_clk = 1'b0;
  logic        osc_a_clk = 1'b0;
  logic        osc_b_clk = 1'b0;
  logic        sys_rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_out;

  localparam realtime P_SYS = 8.0;
  localparam realtime P_A   = 10.0;
  localparam realtime P_B   = 6.0;

  int nchk = 0;
  int nfail = 0;
  int rise_cnt = 0;

  always #(P_SYS/2) sys_clk = ~sys_clk;
  always #(P_A/2)   osc_a_clk = ~osc_a_clk;
  always #(P_B/2)   osc_b_clk = ~osc_b_clk;
  always @(posedge clk_out) rise_cnt++;

  refdiv_top u0 (
    .sys_clk   (sys_clk),
    .sys_rst   (sys_rst),
    .osc_a_clk (osc_a_clk),
    .osc_b_clk (osc_b_clk),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .clk_out   (clk_out)
  );

  function automatic logic [31:0] word(bit en, int sel, int div);
    return {en, 13'd0, 2'(sel), 8'd0, 8'(div)};
  endfunction

  function automatic realtime src_period(int sel);
    return (sel == 0) ? P_SYS : (sel == 1) ? P_A : P_B;
  endfunction

  function automatic bit near(realtime a, realtime b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic check(bit ok, string req, string what);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic write_reg(logic [31:0] d);
    @(negedge sys_clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge sys_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_edge(bit rising, realtime tmo, output bit ok);
    bit hit = 1'b0;
    fork
      begin
        if (rising) @(posedge clk_out);
        else        @(negedge clk_out);
        hit = 1'b1;
      end
      begin
        #(tmo);
      end
    join_any
    disable fork;
    ok = hit;
  endtask

  task automatic no_edges(realtime win, string req);
    int c0 = rise_cnt;
    #(win);
    check(rise_cnt == c0 && clk_out == 1'b0, req,
          $sformatf("rising edges %0d level %0b, expected 0 and 0", rise_cnt - c0, clk_out));
  endtask

  task automatic t_reset();
    repeat (10) @(posedge sys_clk);
    @(negedge sys_clk) sys_rst = 1'b0;
    #1;
    check(rd_data == 32'h0, "R3", $sformatf("rd_data %h expected 00000000", rd_data));
    no_edges(200.0, "R3");
  endtask

  task automatic t_fields();
    write_reg(32'hFFFF_FFFF);
    #1;
    check(rd_data == 32'h8003_00FF, "R1", $sformatf("rd_data %h expected 800300ff", rd_data));
    no_edges(400.0, "R5");
    write_reg(32'h7FFC_FF00);
    #1;
    check(rd_data == 32'h0, "R2", $sformatf("rd_data %h expected 00000000", rd_data));
    write_reg(word(0, 2, 4));
    #1;
    check(rd_data == 32'h0002_0004, "R1", $sformatf("rd_data %h expected 00020004", rd_data));
    repeat (5) @(negedge sys_clk);
    check(rd_data == 32'h0002_0004, "R1", $sformatf("hold %h expected 00020004", rd_data));
    no_edges(400.0, "R4");
  endtask

  task automatic t_period(int sel, int div);
    realtime p = src_period(sel);
    realtime t0, t1, t2, exp_hi;
    realtime tmo = p * (div + 1) * 3 + 200.0;
    bit ok;
    string req = (div == 0) ? "R7" : "R6";
    write_reg(word(1, sel, div));
    #(2000.0 + 3.0 * p * (div + 1));
    wait_edge(1'b1, tmo, ok); t0 = $realtime;
    if (ok) wait_edge(1'b0, tmo, ok);
    t1 = $realtime;
    if (ok) wait_edge(1'b1, tmo, ok);
    t2 = $realtime;
    check(ok, req, $sformatf("sel %0d div %0d edges missing, expected a running clock", sel, div));
    check(near(t2 - t0, p * (div + 1)), req,
          $sformatf("sel %0d div %0d period %0.3f expected %0.3f", sel, div, t2 - t0, p * (div + 1)));
    exp_hi = (div == 0) ? p / 2.0 : p * ((div + 1) / 2);
    check(near(t1 - t0, exp_hi), (div == 0) ? "R7" : "R8",
          $sformatf("sel %0d div %0d high %0.3f expected %0.3f", sel, div, t1 - t0, exp_hi));
  endtask

  task automatic t_change_mid();
    realtime t0, t1, t2, t3;
    bit ok;
    write_reg(word(1, 2, 9));
    #2500.0;
    wait_edge(1'b1, 500.0, ok); t0 = $realtime;
    write_reg(word(1, 2, 3));
    wait_edge(1'b0, 500.0, ok); t1 = $realtime;
    check(near(t1 - t0, 30.0), "R9", $sformatf("high %0.3f expected 30.000", t1 - t0));
    wait_edge(1'b1, 500.0, ok); t2 = $realtime;
    check(near(t2 - t0, 60.0), "R9", $sformatf("old period %0.3f expected 60.000", t2 - t0));
    wait_edge(1'b1, 500.0, ok); t3 = $realtime;
    check(near(t3 - t2, 24.0), "R9", $sformatf("new period %0.3f expected 24.000", t3 - t2));
  endtask

  task automatic t_disable();
    realtime t0, t1;
    bit ok;
    write_reg(word(1, 1, 9));
    #3000.0;
    wait_edge(1'b1, 1000.0, ok); t0 = $realtime;
    write_reg(word(0, 1, 9));
    wait_edge(1'b0, 1000.0, ok); t1 = $realtime;
    check(ok && near(t1 - t0, 50.0), "R10", $sformatf("final high %0.3f expected 50.000", t1 - t0));
    no_edges(400.0, "R10");
  endtask

  initial begin
    #100000.0;
    nchk++;
    nfail++;
    $display("FAIL watchdog: run still going, expected it to end");
    summary();
  end

  initial begin
    t_reset();
    t_fields();
    t_period(0, 0);
    t_period(0, 1);
    t_period(1, 2);
    t_period(1, 4);
    t_period(2, 3);
    t_period(2, 255);
    t_period(1, 0);
    t_change_mid();
    t_disable();
    summary();
  end
endmodule